// File: doc/BRIEF.md
# Digital Input Buffer Gating for Shared Analog Pins

This block drives the enable of the digital input buffer on each pin that is shared between an analog multiplexer and digital I/O. Software writes a per-pin disable mask through a small register port; a pin whose mask bit is set keeps its buffer off at all times. The hardware makes no attempt to guess from the analog channel selection which pins carry analog levels. In active mode the mask alone decides.

When the core enters sleep, every buffer is switched off. The one exception is a pin marked in the wake-source mask: it keeps its buffer on during sleep unless software has disabled it. The block also gates the raw pad values. A pin whose buffer is off presents a constant 0 to the core, so reads and pin-change detection see a stable level while the pad voltage sits near mid-supply.

Top module: `dibuf_ctrl`

## Requirements
- R1: After reset the disable mask reads as all zeros, and every buffer enable is 1 while sleep_i is 0.
- R2: A write (wr_en_i=1) loads wr_data_i into the disable mask at the next rising clock edge. rd_data_o always shows the current mask.
- R3: In active mode (sleep_i=0), buf_en_o[k] is the inverse of mask bit k, whatever wake_mask_i holds.
- R4: While sleep_i=1, buf_en_o[k] is 1 only if wake_mask_i[k]=1 and mask bit k is 0.
- R5: buf_en_o follows sleep_i and wake_mask_i combinationally, with no clock edge in between.
- R6: din_o[k] equals pad_i[k] when buf_en_o[k]=1. Otherwise it is 0.
- R7: While wr_en_i=0 the mask holds its value, including across sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Mask write strobe |
| wr_data_i | input | N_PINS | Mask write data, bit k = disable pin k |
| rd_data_o | output | N_PINS | Current mask value |
| sleep_i | input | 1 | Core is in a sleep mode |
| wake_mask_i | input | N_PINS | Pins configured as wake sources |
| pad_i | input | N_PINS | Raw pad input levels |
| buf_en_o | output | N_PINS | Per-pin input buffer enable |
| din_o | output | N_PINS | Gated digital input values to the core |

## Verification
A corrupted mask bit shows up on rd_data_o one edge after the write that set it. It also shows on buf_en_o and din_o as soon as sleep_i is 0. A fault in the sleep or wake gating shows on buf_en_o in the same cycle that sleep_i or wake_mask_i changes, because no register sits in that path. The bench therefore samples the enables before any clock edge passes.

// File: rtl/dibuf_pkg.sv
package dibuf_pkg;
  localparam int unsigned DEF_PINS = 8;
endpackage

// File: rtl/dibuf_mask_reg.sv
module dibuf_mask_reg #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [N_PINS-1:0] wr_data_i,
  output logic [N_PINS-1:0] mask_o
);
  logic [N_PINS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_en_i) mask_q <= wr_data_i;
  end

  assign mask_o = mask_q;

  // R2
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mask_q == $past(wr_data_i));
  // R7
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q));
endmodule

// File: rtl/dibuf_pin.sv
module dibuf_pin (
  input  logic dis_i,
  input  logic sleep_i,
  input  logic wake_i,
  input  logic pad_i,
  output logic en_o,
  output logic din_o
);
  assign en_o  = ~dis_i & (~sleep_i | wake_i);
  assign din_o = en_o & pad_i;

  always_comb begin
    // R4
    sleep_gate_chk: assert (!(sleep_i && !wake_i && en_o));
    // R6
    din_zero_chk: assert (en_o || !din_o);
  end
endmodule

// File: rtl/dibuf_ctrl.sv
module dibuf_ctrl
  import dibuf_pkg::*;
#(
  parameter int unsigned N_PINS = DEF_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [N_PINS-1:0] wr_data_i,
  output logic [N_PINS-1:0] rd_data_o,
  input  logic              sleep_i,
  input  logic [N_PINS-1:0] wake_mask_i,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] buf_en_o,
  output logic [N_PINS-1:0] din_o
);
  logic [N_PINS-1:0] mask;

  dibuf_mask_reg #(.N_PINS(N_PINS)) u_mask (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .mask_o(mask)
  );

  assign rd_data_o = mask;

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    dibuf_pin u_pin (
      .dis_i  (mask[k]),
      .sleep_i(sleep_i),
      .wake_i (wake_mask_i[k]),
      .pad_i  (pad_i[k]),
      .en_o   (buf_en_o[k]),
      .din_o  (din_o[k])
    );
  end

  // R3
  active_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> buf_en_o == ~rd_data_o);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> rd_data_o == '0);
endmodule

// File: tb/dibuf_ctrl_test.sv
module dibuf_ctrl_test;
  localparam int N = 8;
  logic clk = 0, rst_ni = 0, wr_en = 0, sleep = 0;
  logic [N-1:0] wr_data = '0, wake = '0, pad = '0;
  logic [N-1:0] rd, en, din;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dibuf_ctrl #(.N_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd), .sleep_i(sleep), .wake_mask_i(wake), .pad_i(pad),
    .buf_en_o(en), .din_o(din)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_mask(logic [N-1:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  // mask, sleep, wake, pad
  typedef struct packed { logic [N-1:0] m; logic s; logic [N-1:0] w; logic [N-1:0] p; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h00, 1'b0, 8'hFF, 8'hA5},
    '{8'h0F, 1'b0, 8'h00, 8'hFF},
    '{8'h0F, 1'b1, 8'h00, 8'hFF},
    '{8'h0F, 1'b1, 8'h3C, 8'hFF},
    '{8'h81, 1'b1, 8'hFF, 8'h5A},
    '{8'hF0, 1'b0, 8'h55, 8'h33}
  };

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] e;
    #12;
    chk("R1 mask at reset", rd, '0);
    chk("R1 enables at reset", en, '1);
    rst_ni = 1;
    for (int i = 0; i < 6; i++) begin
      write_mask(VECS[i].m);
      sleep = VECS[i].s; wake = VECS[i].w; pad = VECS[i].p;
      #1;
      e = ~VECS[i].m & (VECS[i].s ? VECS[i].w : '1);
      chk("R2 readback", rd, VECS[i].m);
      chk(VECS[i].s ? "R4 sleep enables" : "R3 active enables", en, e);
      chk("R6 gated data", din, e & VECS[i].p);
    end
    // R5: combinational response without a clock edge
    write_mask(8'h00); sleep = 0; wake = 8'h01; pad = 8'hFF;
    @(negedge clk); #2; sleep = 1; #1;
    chk("R5 sleep entry same cycle", en, 8'h01);
    wake = 8'h03; #1;
    chk("R5 wake change same cycle", en, 8'h03);
    // R7: hold across sleep with no write
    write_mask(8'hC3);
    wr_data = 8'h11; sleep = 1;
    repeat (3) @(negedge clk);
    sleep = 0; #1;
    chk("R7 mask held", rd, 8'hC3);
    chk("R7 enables after wake", en, 8'h3C);
    // R2: write visible only after edge
    @(negedge clk); wr_en = 1; wr_data = 8'h7E; #1;
    chk("R2 before edge", rd, 8'hC3);
    @(negedge clk); wr_en = 0;
    chk("R2 after edge", rd, 8'h7E);
    // R1: async reset clears mask
    #2; rst_ni = 0; #1;
    chk("R1 async clear", rd, 8'h00);
    chk("R1 enables after clear", en, 8'hFF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule